// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of an 8051-style CPU core and produces the internal-RAM address for every stack access. The pointer is built from a low byte and a 3-bit high part. Software reads and writes both through the special-function-register (SFR) bus. A configuration register holds a mode bit. In narrow mode the pointer stays within one 256-byte page and wraps there. In wide mode the pointer is 11 bits and carries and borrows pass between the low byte and the high part.

The CPU sequencer sends single-cycle strobes for push, pop, call and return. A push writes at the incremented pointer. A pop reads at the current pointer and then decrements it. The block expands a call into two consecutive writes and a return into two consecutive reads. It raises a busy flag during the second beat. The access address, a write or read strobe and a byte-select flag are combinational from the strobes, so the RAM can act in the same cycle.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the low pointer byte (SFR 81H) reads 07H, the high part (SFR B7H) reads 00H and the configuration register (SFR AFH) reads 00H.
- R2: A push drives stk_wr_o=1 with stk_addr_o equal to the pointer plus one, and the pointer takes that value at the clock edge. The first push after reset therefore writes address 008H.
- R3: A pop drives stk_rd_o=1 with stk_addr_o equal to the current pointer, and the pointer is decremented at the clock edge.
- R4: In narrow mode (configuration bit 7 clear), only the low byte moves. It wraps from FFH to 00H on push and from 00H to FFH on pop. stk_addr_o[10:8] is 0 and the stored high part is unchanged.
- R5: In wide mode (configuration bit 7 set), stk_addr_o is {high[2:0], low}. An increment from 0FFH gives 100H, a decrement from 100H gives 0FFH, and 7FFH wraps to 000H.
- R6: A call strobe gives two pushes on consecutive cycles. The first writes the low return byte (stk_hi_o=0) and the second writes the high return byte (stk_hi_o=1). busy_o is 1 during the second.
- R7: A return strobe gives two pops on consecutive cycles, the high byte first (stk_hi_o=1) and then the low byte (stk_hi_o=0). busy_o is 1 during the second.
- R8: While busy_o is 1, all strobes are ignored. When several strobes arrive together, call has priority over return, return over push, and push over pop.
- R9: An SFR write to 81H or B7H updates that register at the next clock edge. If a stack operation happens in the same cycle, the access is still issued but the pointer does not move. Only the written value takes effect.
- R10: Only bits 2:0 of the high part are stored, and bits 7:3 of SFR B7H read as zero.
- R11: Bit 7 of SFR AFH is the mode bit. Its other bits read as zero and ignore writes. A read of any address other than 81H, B7H or AFH returns 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational from sfr_addr) |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| call_i | input | 1 | Call request (two pushes) |
| ret_i | input | 1 | Return request (two pops) |
| busy_o | output | 1 | Second beat of a call or return in progress |
| stk_addr_o | output | 11 | RAM address of the current stack access |
| stk_wr_o | output | 1 | Stack write this cycle |
| stk_rd_o | output | 1 | Stack read this cycle |
| stk_hi_o | output | 1 | Access carries the high byte of a return address |

## Verification
Directed runs push and pop around the page boundaries. The same boundary runs are made in both modes, so a carry or borrow into the high part can be told apart from a same-page wrap. Calls and returns are sent alone, with other strobes during the busy beat, and together with other strobes. This separates the byte ordering from the priority and the blocking rules. SFR writes that coincide with pushes and pops show whether the write really wins. A long random mix of strobes and SFR traffic is then compared with the reference model on every cycle.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
    localparam int SP_W_DEF  = 8;
    localparam int HI_W_DEF  = 3;

    localparam logic [7:0] ADDR_SP_DEF  = 8'h81;
    localparam logic [7:0] ADDR_SPH_DEF = 8'hB7;
    localparam logic [7:0] ADDR_CFG_DEF = 8'hAF;
    localparam logic [7:0] SP_RESET_DEF = 8'h07;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL_LO,
        OP_CALL_HI,
        OP_RET_HI,
        OP_RET_LO
    } stk_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CALL2,
        SEQ_RET2
    } seq_e;

    function automatic logic op_is_write(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL_LO) || (op == OP_CALL_HI);
    endfunction

    function automatic logic op_is_read(input stk_op_e op);
        return (op == OP_POP) || (op == OP_RET_HI) || (op == OP_RET_LO);
    endfunction
endpackage

// File: rtl/stkptr_seq.sv
module stkptr_seq
    import stkptr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    call_i,
    input  logic    ret_i,
    output stk_op_e op_o,
    output logic    busy_o
);
    typedef struct packed {
        seq_e seq;
    } seq_state_t;

    seq_state_t st_d, st_q;
    stk_op_e    op_c;

    always_comb begin
        st_d = st_q;
        op_c = OP_NONE;
        unique case (st_q.seq)
            SEQ_CALL2: begin
                op_c       = OP_CALL_HI;
                st_d.seq   = SEQ_IDLE;
            end
            SEQ_RET2: begin
                op_c       = OP_RET_LO;
                st_d.seq   = SEQ_IDLE;
            end
            default: begin
                if (call_i) begin
                    op_c     = OP_CALL_LO;
                    st_d.seq = SEQ_CALL2;
                end else if (ret_i) begin
                    op_c     = OP_RET_HI;
                    st_d.seq = SEQ_RET2;
                end else if (push_i) begin
                    op_c     = OP_PUSH;
                end else if (pop_i) begin
                    op_c     = OP_POP;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{seq: SEQ_IDLE};
        else        st_q <= st_d;
    end

    assign op_o   = op_c;
    assign busy_o = (st_q.seq != SEQ_IDLE);
endmodule

// File: rtl/stkptr_sfr.sv
module stkptr_sfr
    import stkptr_pkg::*;
#(
    parameter int         SP_W     = SP_W_DEF,
    parameter int         HI_W     = HI_W_DEF,
    parameter logic [7:0] ADDR_SP  = ADDR_SP_DEF,
    parameter logic [7:0] ADDR_SPH = ADDR_SPH_DEF,
    parameter logic [7:0] ADDR_CFG = ADDR_CFG_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      sfr_addr,
    input  logic            sfr_wr,
    input  logic [SP_W-1:0] sfr_wdata,
    input  logic [SP_W-1:0] sp_q_i,
    input  logic [HI_W-1:0] sph_q_i,
    output logic [SP_W-1:0] sfr_rdata,
    output logic            wr_sp_o,
    output logic            wr_sph_o,
    output logic            ext_o
);
    localparam int PAD_W = SP_W - HI_W;

    typedef struct packed {
        logic ext;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       sel_sp, sel_sph, sel_cfg;

    always_comb begin
        sel_sp  = (sfr_addr == ADDR_SP);
        sel_sph = (sfr_addr == ADDR_SPH);
        sel_cfg = (sfr_addr == ADDR_CFG);

        st_d = st_q;
        if (sfr_wr && sel_cfg) st_d.ext = sfr_wdata[SP_W-1];

        if (sel_sp)
            sfr_rdata = sp_q_i;
        else if (sel_sph)
            sfr_rdata = {{PAD_W{1'b0}}, sph_q_i};
        else if (sel_cfg)
            sfr_rdata = {st_q.ext, {(SP_W-1){1'b0}}};
        else
            sfr_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ext: 1'b0};
        else        st_q <= st_d;
    end

    assign wr_sp_o  = sfr_wr && sel_sp;
    assign wr_sph_o = sfr_wr && sel_sph;
    assign ext_o    = st_q.ext;
endmodule

// File: rtl/stkptr_ptr.sv
module stkptr_ptr
    import stkptr_pkg::*;
#(
    parameter int             SP_W     = SP_W_DEF,
    parameter int             HI_W     = HI_W_DEF,
    parameter logic [SP_W-1:0] SP_RESET = SP_RESET_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  stk_op_e              op_i,
    input  logic                 ext_i,
    input  logic                 wr_sp_i,
    input  logic                 wr_sph_i,
    input  logic [SP_W-1:0]      wdata_i,
    output logic [SP_W-1:0]      sp_q_o,
    output logic [HI_W-1:0]      sph_q_o,
    output logic [SP_W+HI_W-1:0] stk_addr_o,
    output logic                 stk_wr_o,
    output logic                 stk_rd_o,
    output logic                 stk_hi_o
);
    localparam int PTR_W = SP_W + HI_W;

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic [HI_W-1:0] sph;
    } ptr_state_t;

    ptr_state_t       st_d, st_q;
    logic [PTR_W-1:0] cur, inc, dec, moved;
    logic             is_wr, is_rd;

    always_comb begin
        is_wr = op_is_write(op_i);
        is_rd = op_is_read(op_i);

        if (ext_i) begin
            cur = {st_q.sph, st_q.sp};
            inc = cur + 1'b1;
            dec = cur - 1'b1;
        end else begin
            cur = {{HI_W{1'b0}}, st_q.sp};
            inc = {{HI_W{1'b0}}, st_q.sp + 1'b1};
            dec = {{HI_W{1'b0}}, st_q.sp - 1'b1};
        end

        moved = is_wr ? inc : dec;

        st_d = st_q;
        if (wr_sp_i || wr_sph_i) begin
            if (wr_sp_i)  st_d.sp  = wdata_i;
            if (wr_sph_i) st_d.sph = wdata_i[HI_W-1:0];
        end else if (is_wr || is_rd) begin
            st_d.sp = moved[SP_W-1:0];
            if (ext_i) st_d.sph = moved[PTR_W-1:SP_W];
        end

        stk_addr_o = is_wr ? inc : cur;
        stk_wr_o   = is_wr;
        stk_rd_o   = is_rd;
        stk_hi_o   = (op_i == OP_CALL_HI) || (op_i == OP_RET_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sp: SP_RESET, sph: '0};
        else        st_q <= st_d;
    end

    assign sp_q_o  = st_q.sp;
    assign sph_q_o = st_q.sph;
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int          SP_W     = SP_W_DEF,
    parameter int          HI_W     = HI_W_DEF,
    parameter logic [7:0]  ADDR_SP  = ADDR_SP_DEF,
    parameter logic [7:0]  ADDR_SPH = ADDR_SPH_DEF,
    parameter logic [7:0]  ADDR_CFG = ADDR_CFG_DEF,
    parameter logic [7:0]  SP_RESET = SP_RESET_DEF,
    localparam int         PTR_W    = SP_W + HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       sfr_addr,
    input  logic             sfr_wr,
    input  logic [SP_W-1:0]  sfr_wdata,
    output logic [SP_W-1:0]  sfr_rdata,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             call_i,
    input  logic             ret_i,
    output logic             busy_o,
    output logic [PTR_W-1:0] stk_addr_o,
    output logic             stk_wr_o,
    output logic             stk_rd_o,
    output logic             stk_hi_o
);
    stk_op_e         op;
    logic            ext, wr_sp, wr_sph;
    logic [SP_W-1:0] sp_q;
    logic [HI_W-1:0] sph_q;

    stkptr_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_i),
        .pop_i  (pop_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .op_o   (op),
        .busy_o (busy_o)
    );

    stkptr_sfr #(
        .SP_W     (SP_W),
        .HI_W     (HI_W),
        .ADDR_SP  (ADDR_SP),
        .ADDR_SPH (ADDR_SPH),
        .ADDR_CFG (ADDR_CFG)
    ) u_sfr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sp_q_i    (sp_q),
        .sph_q_i   (sph_q),
        .sfr_rdata (sfr_rdata),
        .wr_sp_o   (wr_sp),
        .wr_sph_o  (wr_sph),
        .ext_o     (ext)
    );

    stkptr_ptr #(
        .SP_W     (SP_W),
        .HI_W     (HI_W),
        .SP_RESET (SP_RESET[SP_W-1:0])
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .ext_i      (ext),
        .wr_sp_i    (wr_sp),
        .wr_sph_i   (wr_sph),
        .wdata_i    (sfr_wdata),
        .sp_q_o     (sp_q),
        .sph_q_o    (sph_q),
        .stk_addr_o (stk_addr_o),
        .stk_wr_o   (stk_wr_o),
        .stk_rd_o   (stk_rd_o),
        .stk_hi_o   (stk_hi_o)
    );
endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk #(
    parameter int         SP_W     = 8,
    parameter int         HI_W     = 3,
    parameter logic [7:0] ADDR_SP  = 8'h81,
    parameter logic [7:0] ADDR_SPH = 8'hB7,
    parameter logic [7:0] ADDR_CFG = 8'hAF,
    localparam int        PTR_W    = SP_W + HI_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       sfr_addr,
    input logic             sfr_wr,
    input logic [SP_W-1:0]  sfr_wdata,
    input logic [SP_W-1:0]  sfr_rdata,
    input logic             push_i,
    input logic             pop_i,
    input logic             call_i,
    input logic             ret_i,
    input logic             busy_o,
    input logic [PTR_W-1:0] stk_addr_o,
    input logic             stk_wr_o,
    input logic             stk_rd_o,
    input logic             stk_hi_o
);
    logic ptr_written;
    assign ptr_written = sfr_wr && ((sfr_addr == ADDR_SP) || (sfr_addr == ADDR_SPH));

    AST_PUSH_PREINC: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr_o && !ptr_written) |=> (sfr_addr != ADDR_SP || sfr_rdata == $past(stk_addr_o[SP_W-1:0]))); // R2

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CFG && !sfr_rdata[SP_W-1] && (stk_wr_o || stk_rd_o)) |-> (stk_addr_o[PTR_W-1:SP_W] == '0)); // R4

    AST_CALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !busy_o) |-> (stk_wr_o && !stk_hi_o) ##1 (stk_wr_o && stk_hi_o && busy_o)); // R6

    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !busy_o) |-> (stk_rd_o && stk_hi_o) ##1 (stk_rd_o && !stk_hi_o && busy_o)); // R7

    AST_BUSY_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R8

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_wr_o && stk_rd_o)); // R8

    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == ADDR_SP) |=> (sfr_addr != ADDR_SP || sfr_rdata == $past(sfr_wdata))); // R9

    AST_SPH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_SPH) |-> (sfr_rdata[SP_W-1:HI_W] == '0)); // R10

    AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CFG) |-> (sfr_rdata[SP_W-2:0] == '0)); // R11
endmodule

bind stkptr_unit stkptr_chk #(
    .SP_W     (SP_W),
    .HI_W     (HI_W),
    .ADDR_SP  (ADDR_SP),
    .ADDR_SPH (ADDR_SPH),
    .ADDR_CFG (ADDR_CFG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rdata  (sfr_rdata),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .busy_o     (busy_o),
    .stk_addr_o (stk_addr_o),
    .stk_wr_o   (stk_wr_o),
    .stk_rd_o   (stk_rd_o),
    .stk_hi_o   (stk_hi_o)
);

// File: tb/stkptr_unit_tb.sv
module stkptr_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        push_i = 1'b0, pop_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic        busy_o;
    logic [10:0] stk_addr_o;
    logic        stk_wr_o, stk_rd_o, stk_hi_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_sp = 7, m_sph = 0, m_ext = 0, m_seq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stkptr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .push_i(push_i), .pop_i(pop_i), .call_i(call_i), .ret_i(ret_i),
        .busy_o(busy_o), .stk_addr_o(stk_addr_o),
        .stk_wr_o(stk_wr_o), .stk_rd_o(stk_rd_o), .stk_hi_o(stk_hi_o)
    );

    // One cycle: drive after the falling edge, compare, advance the model at the rising edge.
    task automatic step(input bit pu, input bit po, input bit ca, input bit re,
                        input bit w, input int a, input int d, input string tag);
        int op, ptr, e_addr, e_rd, nv;
        bit e_wr, e_rdy, e_hi, e_busy, wrote;
        @(negedge clk);
        push_i = pu; pop_i = po; call_i = ca; ret_i = re;
        sfr_wr = w; sfr_addr = a[7:0]; sfr_wdata = d[7:0];
        #1;
        // op codes: 0 none, 1 push, 2 pop, 3 call-lo, 4 call-hi, 5 ret-hi, 6 ret-lo
        if (m_seq == 1) op = 4;
        else if (m_seq == 2) op = 6;
        else if (ca) op = 3;
        else if (re) op = 5;
        else if (pu) op = 1;
        else if (po) op = 2;
        else op = 0;
        e_busy = (m_seq != 0);
        e_wr   = (op == 1 || op == 3 || op == 4);
        e_rdy  = (op == 2 || op == 5 || op == 6);
        e_hi   = (op == 4 || op == 5);
        ptr = m_ext ? m_sph * 256 + m_sp : m_sp;
        if (e_wr) e_addr = m_ext ? (ptr + 1) % 2048 : (m_sp + 1) % 256;
        else      e_addr = ptr;
        if (a == 'h81)      e_rd = m_sp;
        else if (a == 'hB7) e_rd = m_sph;
        else if (a == 'hAF) e_rd = m_ext * 128;
        else                e_rd = 0;
        n_cmp++;
        if (sfr_rdata !== e_rd[7:0] || busy_o !== e_busy || stk_wr_o !== e_wr ||
            stk_rd_o !== e_rdy || stk_hi_o !== e_hi ||
            ((e_wr || e_rdy) && stk_addr_o !== e_addr[10:0])) begin
            n_bad++;
            $display("FAIL %s: rdata=%h/%h busy=%b/%b wr=%b/%b rd=%b/%b hi=%b/%b addr=%h/%h (actual/expected)",
                     tag, sfr_rdata, e_rd[7:0], busy_o, e_busy, stk_wr_o, e_wr,
                     stk_rd_o, e_rdy, stk_hi_o, e_hi, stk_addr_o, e_addr[10:0]);
        end
        // model update
        wrote = w && (a == 'h81 || a == 'hB7);
        if (!wrote && (e_wr || e_rdy)) begin
            if (e_wr) nv = e_addr;
            else      nv = m_ext ? (ptr + 2047) % 2048 : (m_sp + 255) % 256;
            if (m_ext) begin m_sph = nv / 256; m_sp = nv % 256; end
            else m_sp = nv % 256;
        end
        if (w && a == 'h81) m_sp = d % 256;
        if (w && a == 'hB7) m_sph = d % 8;
        if (w && a == 'hAF) m_ext = (d / 128) % 2;
        if (m_seq != 0) m_seq = 0;
        else if (op == 3) m_seq = 1;
        else if (op == 5) m_seq = 2;
        @(posedge clk);
    endtask

    task automatic idle_rd(input int a, input string tag);
        step(0, 0, 0, 0, 0, a, 0, tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(0, 0, 0, 0, 1, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung / expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        idle_rd('h81, "R1");
        idle_rd('hB7, "R1");
        idle_rd('hAF, "R1");
        // R2 pushes from reset, first to 008H
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 'h81, 0, "R2");
        // R3 pops
        for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, 'h81, 0, "R3");
        // R4 narrow wrap
        wr('h81, 'hFE, "R9");
        wr('hB7, 'h05, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 'h81, 0, "R4");
        wr('h81, 'h01, "R9");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 'hB7, 0, "R4");
        idle_rd('hB7, "R4");
        // R11 configuration: reserved bits drop
        wr('hAF, 'hFF, "R11");
        idle_rd('hAF, "R11");
        idle_rd('h55, "R11");
        // R5 wide carry and borrow
        wr('hB7, 'h00, "R5");
        wr('h81, 'hFE, "R5");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 'hB7, 0, "R5");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 'hB7, 0, "R5");
        wr('hB7, 'h07, "R5");
        wr('h81, 'hFF, "R5");
        step(1, 0, 0, 0, 0, 'h81, 0, "R5");
        step(0, 1, 0, 0, 0, 'hB7, 0, "R5");
        // R6 call, R7 return
        step(0, 0, 1, 0, 0, 'h81, 0, "R6");
        idle_rd('h81, "R6");
        step(0, 0, 0, 1, 0, 'h81, 0, "R7");
        idle_rd('h81, "R7");
        // R8 priority and busy blocking
        step(1, 1, 1, 1, 0, 'h81, 0, "R8");
        step(1, 1, 1, 1, 0, 'h81, 0, "R8");
        step(1, 1, 0, 1, 0, 'h81, 0, "R8");
        step(1, 1, 0, 0, 0, 'h81, 0, "R8");
        step(1, 1, 0, 0, 0, 'h81, 0, "R8");
        // R9 write wins over stack movement
        step(1, 0, 0, 0, 1, 'h81, 'h40, "R9");
        step(0, 1, 0, 0, 1, 'hB7, 'h02, "R9");
        idle_rd('h81, "R9");
        // R10 high part upper bits
        wr('hB7, 'hFF, "R10");
        idle_rd('hB7, "R10");
        // back to narrow mode
        wr('hAF, 'h7F, "R11");
        idle_rd('hAF, "R11");
        // random mix
        for (int i = 0; i < 2000; i++) begin
            int r, a;
            r = $urandom % 100;
            case ($urandom % 4)
                0: a = 'h81;
                1: a = 'hB7;
                2: a = 'hAF;
                default: a = $urandom % 256;
            endcase
            step(r < 30, r >= 30 && r < 55, r >= 55 && r < 62, r >= 62 && r < 69,
                 ($urandom % 10) == 0, a, $urandom % 256, "R2");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule